// File: doc/BRIEF.md
# Majority-Vote Serial Receiver With Holding Buffer

This block takes an asynchronous serial line and turns each frame into an 8-bit word. It runs from a system clock and counts a one-cycle oversampling enable that arrives sixteen times per bit period. A falling edge on the synchronised line begins a frame. The line is then sampled on three consecutive ticks in the middle of each bit, and a two-of-three vote gives the bit value. A start bit that does not vote low is taken as noise, and the receiver goes back to waiting.

Data bits collect in a shift register. When the stop bit has been voted, the completed word leaves the shift register. With the FIFO option off, the word goes into a holding register, a full flag is set and an interrupt pulse is raised. With the FIFO option on, the word goes to a FIFO write port, and the full flag is cleared in the same cycle. The host reads the holding register and pulses a read strobe to free it.

The controller has four states: `ST_IDLE`, `ST_START`, `ST_DATA` and `ST_STOP`. Its transitions are:
- **idle-to-start**: a falling edge on the line.
- **false-start**: `ST_START` back to `ST_IDLE` when the start vote is high.
- **start-to-data**: at the 16th tick of the start bit.
- **data-next**: at the 16th tick of each data bit that is not the last one.
- **data-to-stop**: at the 16th tick of the last data bit.
- **stop-done**: `ST_STOP` back to `ST_IDLE` at the stop-bit vote.

Top module: `uart_mv_rx`

## Requirements
- R1: The line passes through two flip-flops before it is used. A falling edge on the synchronised line in idle starts a frame and restarts the tick counter. Each bit then lasts 16 ticks of `os_tick`, numbered 1 to 16, and clock cycles without `os_tick` do not advance the count.
- R2: Each bit is sampled on ticks 7, 8 and 9 of its period. The bit value is the majority of those three samples, so one wrong sample among them does not change the result. Samples on other ticks have no effect.
- R3: If the start bit votes high, the receiver returns to idle. In that case no word is delivered and no output changes.
- R4: A frame is one start bit (low), 8 data bits sent least significant bit first, and one stop bit. The word completes on tick 9 of the stop bit, and all outputs for that word appear together, one clock after that tick.
- R5: With `fifo_mode`=0, a completed word is written to `hold_data` and `hold_full` is set. `rx_irq` goes high for exactly one cycle, in the same cycle that `hold_full` rises.
- R6: With `fifo_mode`=1, a completed word appears on `fifo_wdata` with a one-cycle `fifo_wr` pulse. In that same cycle `hold_full` is 0, `hold_data` is unchanged and `rx_irq` stays low.
- R7: A `rd_strobe` pulse clears `hold_full` and `overrun`. If a read and a word completion happen in the same cycle, the read is applied first, so the new word is accepted.
- R8: With `fifo_mode`=0, a word that completes while `hold_full`=1 and no read is pending sets `overrun`. That word is discarded: `hold_data` is kept and no `rx_irq` is raised.
- R9: `frame_err` is 1 when the stop bit of the most recently completed frame voted low, and 0 otherwise. It is updated on every completion, in every mode, including one that overruns.
- R10: After reset, `hold_full`, `rx_irq`, `fifo_wr`, `frame_err` and `overrun` are 0, and `hold_data` and `fifo_wdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| fifo_mode | input | 1 | 1 sends words to the FIFO port, 0 to the holding register |
| rd_strobe | input | 1 | Host read pulse; clears full and overrun flags |
| hold_data | output | 8 | Holding register contents |
| hold_full | output | 1 | Holding register contains an unread word |
| rx_irq | output | 1 | One-cycle receive interrupt (FIFO off) |
| fifo_wdata | output | 8 | Word presented to the FIFO |
| fifo_wr | output | 1 | One-cycle FIFO write pulse |
| frame_err | output | 1 | Stop bit of the last frame voted low |
| overrun | output | 1 | A word was dropped while the register was full |

## Verification
The hardest case to reach is a host read that lands in the same clock edge as the stop-bit vote, because that edge depends on when the frame started, the two synchroniser stages and the tick spacing. The bench drives the line one tick period at a time, so it knows exactly which edge carries tick 9 of the stop bit. It raises `rd_strobe` together with that tick, after leaving the register full and the overrun flag set. Vote tolerance is exercised by flipping random ticks inside data bits. Two flips can land in the sampling window, and then the expected word is taken from the bench's own majority function.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_mv_sync.sv
module uart_mv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_mv_voter.sv
module uart_mv_voter #(
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(OVS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rx,
    output logic             vote_valid,
    output logic             vote
);
    // Sampling ticks are numbered 1..OVS; counter value k marks tick k+1.
    localparam logic [CNT_W-1:0] SMP0 = CNT_W'(OVS/2 - 2);
    localparam logic [CNT_W-1:0] SMP1 = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] SMP2 = CNT_W'(OVS/2);

    logic smp_a;
    logic smp_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (tick) begin
            if (cnt == SMP0) smp_a <= rx;
            if (cnt == SMP1) smp_b <= rx;
        end
    end

    assign vote_valid = tick && (cnt == SMP2);
    assign vote       = (smp_a & smp_b) | (smp_a & rx) | (smp_b & rx);
endmodule

// File: rtl/uart_mv_ctrl.sv
module uart_mv_ctrl
    import uart_mv_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    output logic              done,
    output logic              stop_ok,
    output logic [DATA_W-1:0] word
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_e         state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              rx_d;
    logic              fall;
    logic              bit_end;
    logic              vote_valid;
    logic              vote;

    uart_mv_voter #(.OVS(OVS), .CNT_W(CNT_W)) u_voter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cnt        (cnt),
        .rx         (rx_s),
        .vote_valid (vote_valid),
        .vote       (vote)
    );

    assign fall    = rx_d & ~rx_s;
    assign bit_end = tick && (cnt == CNT_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (fall) state_nx = ST_START;
            ST_START: begin
                if (vote_valid && vote) state_nx = ST_IDLE;
                else if (bit_end)       state_nx = ST_DATA;
            end
            ST_DATA:  if (bit_end && bit_idx == BIT_LAST) state_nx = ST_STOP;
            ST_STOP:  if (vote_valid) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_d    <= 1'b1;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            rx_d <= rx_s;
            if (state == ST_IDLE) begin
                cnt     <= '0;
                bit_idx <= '0;
            end else if (tick) begin
                cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
            end
            if (state == ST_DATA) begin
                if (vote_valid) shreg <= {vote, shreg[DATA_W-1:1]};
                if (bit_end && bit_idx != BIT_LAST) bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    always_comb begin
        done    = 1'b0;
        stop_ok = 1'b1;
        word    = shreg;
        unique case (state)
            ST_IDLE, ST_START, ST_DATA: done = 1'b0;
            ST_STOP: begin
                done    = vote_valid;
                stop_ok = vote;
            end
            default: done = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_mv_hold.sv
module uart_mv_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              stop_ok,
    input  logic [DATA_W-1:0] word,
    input  logic              fifo_mode,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              rx_irq,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_wr,
    output logic              frame_err,
    output logic              overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_full  <= 1'b0;
            rx_irq     <= 1'b0;
            fifo_wdata <= '0;
            fifo_wr    <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            rx_irq  <= 1'b0;
            fifo_wr <= 1'b0;
            if (rd_strobe) begin
                hold_full <= 1'b0;
                overrun   <= 1'b0;
            end
            if (done) begin
                frame_err <= ~stop_ok;
                if (fifo_mode) begin
                    fifo_wdata <= word;
                    fifo_wr    <= 1'b1;
                    hold_full  <= 1'b0;
                end else if (hold_full && !rd_strobe) begin
                    overrun <= 1'b1;
                end else begin
                    hold_data <= word;
                    hold_full <= 1'b1;
                    rx_irq    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd_in,
    input  logic              fifo_mode,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              rx_irq,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_wr,
    output logic              frame_err,
    output logic              overrun
);
    logic              rx_s;
    logic              done;
    logic              stop_ok;
    logic [DATA_W-1:0] word;

    uart_mv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_in),
        .dout (rx_s)
    );

    uart_mv_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .rx_s   (rx_s),
        .done   (done),
        .stop_ok(stop_ok),
        .word   (word)
    );

    uart_mv_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .stop_ok   (stop_ok),
        .word      (word),
        .fifo_mode (fifo_mode),
        .rd_strobe (rd_strobe),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .rx_irq    (rx_irq),
        .fifo_wdata(fifo_wdata),
        .fifo_wr   (fifo_wr),
        .frame_err (frame_err),
        .overrun   (overrun)
    );
endmodule

// File: rtl/uart_mv_rx_chk.sv
module uart_mv_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_mode,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] hold_data,
    input logic              hold_full,
    input logic              rx_irq,
    input logic              fifo_wr,
    input logic              overrun
);
    // R5: interrupt only together with a full holding register
    a_r5_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> hold_full);

    // R5: interrupt lasts a single cycle
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R6: FIFO write leaves the full flag clear and raises no interrupt
    a_r6_fifo_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (!hold_full && !rx_irq));

    // R6: FIFO write is a single-cycle pulse
    a_r6_fifo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr);

    // R8: a dropped word leaves the holding register untouched
    a_r8_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($stable(hold_data) && !rx_irq));

    // R7: a read strobe leaves no overrun behind
    a_r7_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !overrun);
endmodule

bind uart_mv_rx uart_mv_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_mode(fifo_mode),
    .rd_strobe(rd_strobe),
    .hold_data(hold_data),
    .hold_full(hold_full),
    .rx_irq   (rx_irq),
    .fifo_wr  (fifo_wr),
    .overrun  (overrun)
);

// File: tb/uart_mv_rx_tb.sv
module uart_mv_rx_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd_in = 1'b1;
    logic       fifo_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] hold_data;
    logic       hold_full;
    logic       rx_irq;
    logic [7:0] fifo_wdata;
    logic       fifo_wr;
    logic       frame_err;
    logic       overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_data;
    logic       m_full;
    logic       m_ovr;
    logic       m_ferr;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_mv_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_in(rxd_in),
        .fifo_mode(fifo_mode), .rd_strobe(rd_strobe), .hold_data(hold_data),
        .hold_full(hold_full), .rx_irq(rx_irq), .fifo_wdata(fifo_wdata),
        .fifo_wr(fifo_wr), .frame_err(frame_err), .overrun(overrun)
    );

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a && b) || (a && c) || (b && c);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One tick period: line value held, tick on the fourth clock edge.
    task automatic tperiod(input logic v, input logic rd);
        rxd_in = v;
        repeat (3) @(negedge clk);
        os_tick   = 1'b1;
        rd_strobe = rd;
        @(negedge clk);
        os_tick   = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tperiod(1'b1, 1'b0);
    endtask

    // Sends one frame up to tick 9 of the stop bit; returns voted word and stop.
    task automatic send_frame(input logic [7:0] d, input logic stopv, input bit noisy,
                              input bit rd_end, output logic [7:0] ew, output logic es);
        logic [16:1] arr;
        logic        v;
        for (int b = 0; b < 10; b++) begin
            v = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
            arr = {16{v}};
            if (noisy) begin
                arr[2 + ($urandom % 15)] ^= 1'b1;
                if (b >= 1 && b <= 8) arr[2 + ($urandom % 15)] ^= 1'b1;
            end
            if (b >= 1 && b <= 8) ew[b-1] = maj3(arr[7], arr[8], arr[9]);
            if (b == 9) es = maj3(arr[7], arr[8], arr[9]);
            for (int t = 1; t <= ((b == 9) ? 9 : 16); t++)
                tperiod(arr[t], (b == 9 && t == 9) ? rd_end : 1'b0);
        end
    endtask

    task automatic model_done(input logic [7:0] w, input logic s, input bit rd);
        if (rd) begin m_full = 1'b0; m_ovr = 1'b0; end
        m_ferr = ~s;
        if (fifo_mode) m_full = 1'b0;
        else if (m_full) m_ovr = 1'b1;
        else begin m_data = w; m_full = 1'b1; end
    endtask

    task automatic check_after(input logic [7:0] w, input bit was_full, input bit rd);
        bit accept;
        accept = !fifo_mode && !(was_full && !rd);
        chk(hold_full === m_full, "R5/R7 hold_full", hold_full, m_full);
        chk(hold_data === m_data, "R4/R8 hold_data", hold_data, m_data);
        chk(rx_irq === accept, "R5/R8 rx_irq", rx_irq, accept);
        chk(fifo_wr === fifo_mode, "R6 fifo_wr", fifo_wr, fifo_mode);
        if (fifo_mode) chk(fifo_wdata === w, "R6 fifo_wdata", fifo_wdata, w);
        chk(frame_err === m_ferr, "R9 frame_err", frame_err, m_ferr);
        chk(overrun === m_ovr, "R8 overrun", overrun, m_ovr);
        @(negedge clk);
        chk(rx_irq === 1'b0 && fifo_wr === 1'b0, "R5/R6 pulse width", {rx_irq, fifo_wr}, 0);
    endtask

    task automatic frame(input logic [7:0] d, input logic stopv, input bit noisy, input bit rd_end);
        logic [7:0] ew;
        logic       es;
        bit         wf;
        wf = m_full;
        send_frame(d, stopv, noisy, rd_end, ew, es);
        model_done(ew, es, rd_end);
        check_after(ew, wf, rd_end);
        idle(9);
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_full = 1'b0;
        m_ovr  = 1'b0;
        chk(hold_full === 1'b0 && overrun === 1'b0, "R7 read clears", {hold_full, overrun}, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        m_data = '0; m_full = 1'b0; m_ovr = 1'b0; m_ferr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({hold_full, rx_irq, fifo_wr, frame_err, overrun} === 5'b0, "R10 flags", 
            {hold_full, rx_irq, fifo_wr, frame_err, overrun}, 0);
        chk(hold_data === 8'h00 && fifo_wdata === 8'h00, "R10 data", {hold_data, fifo_wdata}, 0);
        idle(3);

        // R1 R4: clean frame, LSB first
        frame(8'hA5, 1'b1, 1'b0, 1'b0);
        host_read();

        // R2: single wrong sample inside the voting window is outvoted
        frame(8'h3C, 1'b1, 1'b1, 1'b0);
        host_read();

        // R3: false start, low only until tick 6; nothing may change
        for (int t = 1; t <= 6; t++) tperiod(1'b0, 1'b0);
        idle(30);
        chk(hold_full === 1'b0 && overrun === 1'b0, "R3 false start ignored", {hold_full, overrun}, 0);
        chk(hold_data === m_data, "R3 hold_data kept", hold_data, m_data);
        // R1: clock cycles without tick do not advance the count
        rxd_in = 1'b0;
        repeat (40) @(negedge clk);
        frame(8'h81, 1'b1, 1'b0, 1'b0);  // line already low: edge seen earlier
        host_read();

        // R9: stop bit low
        frame(8'h5A, 1'b0, 1'b0, 1'b0);
        // R8: overrun without a read
        frame(8'hF0, 1'b1, 1'b0, 1'b0);
        // R7: read lands on the completing edge
        frame(8'h0F, 1'b1, 1'b0, 1'b1);
        // R6: FIFO mode while holding register is full
        fifo_mode = 1'b1;
        frame(8'hC3, 1'b1, 1'b1, 1'b0);
        fifo_mode = 1'b0;

        // Random frames
        for (int i = 0; i < 24; i++) begin
            fifo_mode = ($urandom % 3) == 0;
            frame(8'($urandom), ($urandom % 4) != 0, 1'b1, ($urandom % 5) == 0);
            if (($urandom % 2) == 0) host_read();
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule